// File: doc/BRIEF.md
# Block-Coded ADPCM Sample Decoder

This block expands a compressed byte stream, pulled one byte at a time from a sample FIFO, into 8-bit offset-binary playback samples. The stream is cut into packets of fifteen bytes. The first byte of a packet is a header. Its low nibble sets a right-shift amount and its high nibble selects one of sixteen predictor filters. The fourteen bytes that follow carry twenty-eight 4-bit codes. Each code is scaled by the shift and added to a two-tap prediction built from the last two decoded outputs. The two filter coefficients of that prediction are signed bytes held in a small table that the host can write.

The block is a pull stage. A playback engine pulses `reqValid` whenever it wants a sample, and the decoder answers with exactly one `outValid` pulse that carries the sample byte. When the FIFO control value does not select decoding, each request passes one FIFO byte through unchanged. A FIFO clear from the surrounding logic restarts packet parsing with a header fetch. It leaves the predictor history as it was.

Top module: `adpcm_decoder`

## Requirements
- R1: When `fifoCtrl & 0x83` is not 0x82, a request pops one byte if the FIFO holds data and returns that byte unchanged, with `outValid` rising one cycle after the request.
- R2: When `fifoCtrl & 0x83` equals 0x82 and a packet is starting, a request pops the header byte and then the first data byte, and the sample appears two cycles after the request. Later samples in the packet appear one cycle after their request.
- R3: Header bits [3:0] give the shift and bits [7:4] give the filter index n. The coefficient applied to the newer history value is table byte 2n+1, and the one applied to the older value is table byte 2n. All table bytes are signed and reset to zero.
- R4: Each data byte yields two samples. The low nibble comes first and is popped with the byte; the high nibble comes second and needs no pop. Either nibble is placed in bits [15:12] of a signed 16-bit value.
- R5: Each sample is t = (d >>> shift) + ((h0·f0 + h1·f1 + 32) >>> 6), clamped to the range −32768 to 32767.
- R6: A packet is exactly 28 samples and 15 pops. The request after the 28th sample fetches a new header.
- R7: The output byte is t/256, truncated toward zero, with bit 7 inverted.
- R8: If the FIFO is empty when a header or data byte is needed, the output is 0x80 and the packet position does not advance. A header that was already consumed stays in effect.
- R9: The decoder never pops an empty FIFO.
- R10: After each decoded sample the history shifts as h1 ← h0 and h0 ← t, where t is the clamped value. Reset sets both history values to zero, and `outValid` is low during reset.
- R11: A one-cycle `fifoClear` makes the next decode request start with a header fetch and keeps the history values.
- R12: Shift values from 13 to 15 are applied as they are, so the code's contribution shrinks toward its sign bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoCtrl | input | 8 | FIFO control value; a masked value of 0x82 selects decoding |
| coefWe | input | 1 | Coefficient table write strobe |
| coefAddr | input | 5 | Coefficient table byte index |
| coefData | input | 8 | Signed coefficient byte to write |
| fifoClear | input | 1 | FIFO clear pulse; restarts packet parsing |
| fifoEmpty | input | 1 | FIFO holds no byte |
| fifoData | input | 8 | Byte at the FIFO head |
| fifoPop | output | 1 | Consume the byte at the FIFO head this cycle |
| reqValid | input | 1 | Sample request pulse |
| outValid | output | 1 | Sample byte valid pulse |
| outSample | output | 8 | Offset-binary sample byte |

## Verification
The assertions take for granted that a new request arrives only after the previous request has been answered. They also assume that `fifoData` shows the head byte whenever `fifoEmpty` is low, and that `fifoClear` and coefficient writes never overlap an unanswered request. The bench keeps to these rules. It waits for each `outValid` before it issues the next request, and it changes the FIFO, the table and the clear only while the decoder is idle. Its FIFO model drops bytes only on the cycles in which `fifoPop` is high.

// File: rtl/adpcm_pkg.sv
package adpcm_pkg;

  localparam logic [7:0] DEC_MASK  = 8'h83;
  localparam logic [7:0] DEC_MATCH = 8'h82;

  typedef struct packed {
    logic loadHdr;     // capture header byte from FIFO head
    logic emitRaw;     // output FIFO head byte unchanged
    logic emitSilent;  // output midscale, no state change
    logic emitSample;  // decode one nibble, update history
    logic useHigh;     // nibble from stored byte high half
  } dpCtrl_t;

endpackage

// File: rtl/adpcm_ctrl.sv
module adpcm_ctrl
  import adpcm_pkg::*;
#(
  parameter int SAMPLES_PER_PKT = 28,
  localparam int CNT_W = $clog2(SAMPLES_PER_PKT)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] fifoCtrl,
  input  logic       fifoClear,
  input  logic       fifoEmpty,
  input  logic       reqValid,
  output logic       fifoPop,
  output dpCtrl_t    st
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SAMPLES_PER_PKT - 1);

  typedef enum logic {S_IDLE, S_DATA} state_t;

  state_t          state, nextState;
  logic [CNT_W-1:0] pktCount;
  logic            hdrValid;
  logic            decodeOn;

  assign decodeOn = (fifoCtrl & DEC_MASK) == DEC_MATCH;

  always_comb begin
    st        = '0;
    fifoPop   = 1'b0;
    nextState = state;
    if (!fifoClear) begin
      if (state == S_DATA || (reqValid && decodeOn && hdrValid)) begin
        nextState = S_IDLE;
        if (!pktCount[0]) begin
          if (fifoEmpty) begin
            st.emitSilent = 1'b1;
          end else begin
            fifoPop       = 1'b1;
            st.emitSample = 1'b1;
          end
        end else begin
          st.emitSample = 1'b1;
          st.useHigh    = 1'b1;
        end
      end else if (reqValid && !decodeOn) begin
        if (fifoEmpty) begin
          st.emitSilent = 1'b1;
        end else begin
          fifoPop    = 1'b1;
          st.emitRaw = 1'b1;
        end
      end else if (reqValid) begin
        if (fifoEmpty) begin
          st.emitSilent = 1'b1;
        end else begin
          fifoPop    = 1'b1;
          st.loadHdr = 1'b1;
          nextState  = S_DATA;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      pktCount <= '0;
      hdrValid <= 1'b0;
    end else if (fifoClear) begin
      state    <= S_IDLE;
      pktCount <= '0;
      hdrValid <= 1'b0;
    end else begin
      state <= nextState;
      if (st.loadHdr) hdrValid <= 1'b1;
      if (st.emitSample) begin
        if (pktCount == LAST_IDX) begin
          pktCount <= '0;
          hdrValid <= 1'b0;
        end else begin
          pktCount <= pktCount + 1'b1;
        end
      end
    end
  end

  a_r9_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !fifoEmpty);

  a_r6_count_in_packet: assert property (@(posedge clk) disable iff (!rstN)
    pktCount <= LAST_IDX);

  a_r11_clear_restarts: assert property (@(posedge clk) disable iff (!rstN)
    fifoClear |=> (!hdrValid && pktCount == '0 && state == S_IDLE));

  a_r2_header_then_data: assert property (@(posedge clk) disable iff (!rstN)
    (st.loadHdr && !fifoClear) |=> (state == S_DATA && hdrValid));

endmodule

// File: rtl/adpcm_dp.sv
module adpcm_dp
  import adpcm_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SAMPLE_W   = 16,
  parameter int PRED_SHIFT = 6,
  localparam int NIB_W      = DATA_W / 2,
  localparam int TBL_ADDR_W = NIB_W + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtrl_t               st,
  input  logic [DATA_W-1:0]     fifoData,
  input  logic                  coefWe,
  input  logic [TBL_ADDR_W-1:0] coefAddr,
  input  logic [DATA_W-1:0]     coefData,
  output logic                  outValid,
  output logic [DATA_W-1:0]     outSample
);

  localparam int TBL_DEPTH = 1 << TBL_ADDR_W;
  localparam int ACC_W     = SAMPLE_W + DATA_W + 2;
  localparam int T_W       = ACC_W + 1;
  localparam int OUT_SHIFT = SAMPLE_W - DATA_W;
  localparam int ROUND     = 1 << (PRED_SHIFT - 1);
  localparam logic [DATA_W-1:0] SIGN_FLIP = DATA_W'(1 << (DATA_W - 1));
  localparam logic signed [T_W-1:0] SAT_HI = T_W'((1 << (SAMPLE_W - 1)) - 1);
  localparam logic signed [T_W-1:0] SAT_LO = T_W'(-(1 << (SAMPLE_W - 1)));

  logic signed [DATA_W-1:0] coefArr [TBL_DEPTH];

  for (genvar g = 0; g < TBL_DEPTH; g++) begin : gCoef
    logic signed [DATA_W-1:0] entry;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) entry <= '0;
      else if (coefWe && coefAddr == TBL_ADDR_W'(g)) entry <= coefData;
    end
    assign coefArr[g] = entry;
  end

  logic [DATA_W-1:0]          hdrReg, byteReg;
  logic signed [SAMPLE_W-1:0] hist0, hist1;

  logic [NIB_W-1:0]           shiftAmt, nib;
  logic [DATA_W-NIB_W-1:0]    filtSel;
  logic signed [SAMPLE_W-1:0] dVal, dShifted;
  logic signed [ACC_W-1:0]    h0w, h1w, f0w, f1w, acc, pred;
  logic signed [T_W-1:0]      tSum;
  logic signed [SAMPLE_W-1:0] tSat, qFloor;
  logic [SAMPLE_W-1:0]        qTrunc;
  logic                       roundUp;
  logic [DATA_W-1:0]          decByte;

  always_comb begin
    shiftAmt = hdrReg[NIB_W-1:0];
    filtSel  = hdrReg[DATA_W-1:NIB_W];
    nib      = st.useHigh ? byteReg[DATA_W-1:NIB_W] : fifoData[NIB_W-1:0];
    dVal     = $signed({nib, {(SAMPLE_W - NIB_W){1'b0}}});
    dShifted = dVal >>> shiftAmt;

    h0w  = ACC_W'(hist0);
    h1w  = ACC_W'(hist1);
    f0w  = ACC_W'(coefArr[{filtSel, 1'b1}]);
    f1w  = ACC_W'(coefArr[{filtSel, 1'b0}]);
    acc  = h0w * f0w + h1w * f1w + ACC_W'(ROUND);
    pred = acc >>> PRED_SHIFT;

    tSum = T_W'(dShifted) + T_W'(pred);
    if (tSum > SAT_HI)      tSat = SAMPLE_W'(SAT_HI);
    else if (tSum < SAT_LO) tSat = SAMPLE_W'(SAT_LO);
    else                    tSat = SAMPLE_W'(tSum);

    qFloor  = tSat >>> OUT_SHIFT;
    roundUp = tSat[SAMPLE_W-1] && (tSat[OUT_SHIFT-1:0] != '0);
    qTrunc  = qFloor + {{(SAMPLE_W - 1){1'b0}}, roundUp};
    decByte = qTrunc[DATA_W-1:0] ^ SIGN_FLIP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrReg    <= '0;
      byteReg   <= '0;
      hist0     <= '0;
      hist1     <= '0;
      outValid  <= 1'b0;
      outSample <= SIGN_FLIP;
    end else begin
      outValid <= st.emitSample | st.emitRaw | st.emitSilent;
      if (st.loadHdr) hdrReg <= fifoData;
      if (st.emitSample && !st.useHigh) byteReg <= fifoData;
      if (st.emitSample) begin
        hist1     <= hist0;
        hist0     <= tSat;
        outSample <= decByte;
      end else if (st.emitRaw) begin
        outSample <= fifoData;
      end else if (st.emitSilent) begin
        outSample <= SIGN_FLIP;
      end
    end
  end

  a_r10_history_holds: assert property (@(posedge clk) disable iff (!rstN)
    !st.emitSample |=> ($stable(hist0) && $stable(hist1)));

  a_r10_history_shifts: assert property (@(posedge clk) disable iff (!rstN)
    st.emitSample |=> (hist1 == $past(hist0)));

  a_r8_silent_midscale: assert property (@(posedge clk) disable iff (!rstN)
    st.emitSilent |=> (outValid && outSample == SIGN_FLIP));

endmodule

// File: rtl/adpcm_decoder.sv
module adpcm_decoder
  import adpcm_pkg::*;
#(
  parameter int DATA_W          = 8,
  parameter int SAMPLE_W        = 16,
  parameter int PRED_SHIFT      = 6,
  parameter int SAMPLES_PER_PKT = 28,
  localparam int TBL_ADDR_W     = DATA_W / 2 + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [7:0]            fifoCtrl,
  input  logic                  coefWe,
  input  logic [TBL_ADDR_W-1:0] coefAddr,
  input  logic [DATA_W-1:0]     coefData,
  input  logic                  fifoClear,
  input  logic                  fifoEmpty,
  input  logic [DATA_W-1:0]     fifoData,
  output logic                  fifoPop,
  input  logic                  reqValid,
  output logic                  outValid,
  output logic [DATA_W-1:0]     outSample
);

  dpCtrl_t st;

  adpcm_ctrl #(.SAMPLES_PER_PKT(SAMPLES_PER_PKT)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .fifoCtrl  (fifoCtrl),
    .fifoClear (fifoClear),
    .fifoEmpty (fifoEmpty),
    .reqValid  (reqValid),
    .fifoPop   (fifoPop),
    .st        (st)
  );

  adpcm_dp #(.DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W), .PRED_SHIFT(PRED_SHIFT)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .fifoData  (fifoData),
    .coefWe    (coefWe),
    .coefAddr  (coefAddr),
    .coefData  (coefData),
    .outValid  (outValid),
    .outSample (outSample)
  );

  a_r1_one_answer_per_request: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

endmodule

// File: tb/tb_adpcm_decoder.sv
module tb_adpcm_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] fifoCtrl;
  logic       coefWe;
  logic [4:0] coefAddr;
  logic [7:0] coefData;
  logic       fifoClear;
  logic       fifoEmpty;
  logic [7:0] fifoData;
  logic       fifoPop;
  logic       reqValid;
  logic       outValid;
  logic [7:0] outSample;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adpcm_decoder dut (
    .clk(clk), .rstN(rstN), .fifoCtrl(fifoCtrl), .coefWe(coefWe),
    .coefAddr(coefAddr), .coefData(coefData), .fifoClear(fifoClear),
    .fifoEmpty(fifoEmpty), .fifoData(fifoData), .fifoPop(fifoPop),
    .reqValid(reqValid), .outValid(outValid), .outSample(outSample)
  );

  // FIFO model
  logic [7:0] mem [0:1023];
  int wr = 0;
  int rd = 0;
  int popCnt = 0;
  int popEmptyErr = 0;
  assign fifoEmpty = (rd == wr);
  assign fifoData  = mem[rd % 1024];

  always @(posedge clk) begin
    if (fifoClear) rd <= wr;
    else if (fifoPop) begin
      if (rd == wr) popEmptyErr <= popEmptyErr + 1;
      else rd <= rd + 1;
      popCnt <= popCnt + 1;
    end
  end

  int checks = 0;
  int errors = 0;
  int cf [32];
  int pkt [15];
  int got [28];
  int h0 = 0;
  int h1 = 0;

  // ctrl, input byte, expected output
  localparam logic [23:0] RAW_VEC [0:5] = '{
    {8'h80, 8'h3C, 8'h3C},
    {8'h00, 8'hA5, 8'hA5},
    {8'h02, 8'h00, 8'h00},
    {8'h83, 8'hFF, 8'hFF},
    {8'h81, 8'h80, 8'h80},
    {8'h7F, 8'h5A, 8'h5A}
  };

  task automatic chk(string tag, int gotV, int expV);
    checks++;
    if (gotV !== expV) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, gotV, expV);
    end
  endtask

  task automatic push(int b);
    mem[wr % 1024] = 8'(b);
    wr = wr + 1;
  endtask

  task automatic writeCoef(int addr, int val);
    @(negedge clk);
    coefWe = 1'b1; coefAddr = 5'(addr); coefData = 8'(val);
    @(negedge clk);
    coefWe = 1'b0;
    cf[addr] = (val >= 128) ? val - 256 : val;
  endtask

  task automatic doReq(output int val, output int lat, output int pops);
    int p0;
    @(negedge clk);
    p0 = popCnt;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!outValid && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    val  = outSample;
    pops = popCnt - p0;
  endtask

  task automatic loadPacket(int hdr, int seed, bit fill);
    pkt[0] = hdr;
    for (int k = 1; k < 15; k++)
      pkt[k] = fill ? seed : ((k == 1) ? seed : ((seed + k * 77 + k * k) & 255));
    for (int k = 0; k < 15; k++) push(pkt[k]);
  endtask

  task automatic runSamples(int first, int cnt, bit hdrDone, string tag);
    for (int i = first; i < first + cnt; i++) begin
      int bv, nib, d, sh, fl, f0, f1, t, expV, v, lat, pops;
      bit needHdr;
      bv  = pkt[1 + i / 2];
      nib = (i % 2 == 0) ? (bv & 15) : (bv >> 4);
      d   = nib << 12;
      if (d >= 32768) d = d - 65536;
      sh  = pkt[0] & 15;
      fl  = pkt[0] >> 4;
      f0  = cf[2 * fl + 1];
      f1  = cf[2 * fl];
      t   = (d >>> sh) + ((h0 * f0 + h1 * f1 + 32) >>> 6);
      if (t > 32767) t = 32767;
      if (t < -32768) t = -32768;
      expV = ((t / 256) & 255) ^ 128;
      needHdr = (i == 0) && !hdrDone;
      doReq(v, lat, pops);
      chk(tag, v, expV);
      chk("R4 pops per sample", pops, ((i % 2 == 0) ? 1 : 0) + (needHdr ? 1 : 0));
      chk("R2 latency", lat, needHdr ? 2 : 1);
      h1 = h0;
      h0 = t;
      got[i] = v;
    end
  endtask

  initial begin
    int v, lat, pops, p0;
    rstN = 1'b0; fifoCtrl = 8'h00; coefWe = 1'b0; coefAddr = '0; coefData = '0;
    fifoClear = 1'b0; reqValid = 1'b0;
    for (int k = 0; k < 32; k++) cf[k] = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset outValid", outValid, 0);
    chk("R10 reset fifoPop", fifoPop, 0);
    rstN = 1'b1;

    writeCoef(3, 8'h3C); writeCoef(2, 8'hCC);
    writeCoef(5, 8'h73); writeCoef(4, 8'hCC);
    writeCoef(7, 8'h7F); writeCoef(6, 8'h7F);

    // R1 raw pass-through table
    for (int n = 0; n < 6; n++) begin
      fifoCtrl = RAW_VEC[n][23:16];
      push(RAW_VEC[n][15:8]);
      doReq(v, lat, pops);
      chk("R1 raw value", v, RAW_VEC[n][7:0]);
      chk("R1 raw latency", lat, 1);
      chk("R1 raw pops", pops, 1);
    end
    doReq(v, lat, pops);
    chk("R8 raw empty value", v, 8'h80);
    chk("R8 raw empty pops", pops, 0);

    // first packet, history zero from reset
    fifoCtrl = 8'h82;
    p0 = popCnt;
    loadPacket(8'h00, 8'h71, 0);
    runSamples(0, 28, 0, "R5 packet zero coef");
    chk("R6 pops per packet", popCnt - p0, 15);
    chk("R7 R10 first sample", got[0], 8'h90);
    chk("R4 R7 second sample", got[1], 8'hF0);

    fifoCtrl = 8'h86;
    loadPacket(8'h12, 8'h5A, 0);
    runSamples(0, 28, 0, "R3 filter one");
    loadPacket(8'h21, 8'hC3, 0);
    runSamples(0, 28, 0, "R3 filter two");

    loadPacket(8'h1D, 8'h9E, 0);
    runSamples(0, 28, 0, "R12 shift thirteen");
    loadPacket(8'h0F, 8'h88, 1);
    runSamples(0, 28, 0, "R12 shift fifteen");
    chk("R7 truncation of minus one", got[5], 8'h80);

    loadPacket(8'h50, 8'h77, 1);
    runSamples(0, 28, 0, "R5 flat positive");
    loadPacket(8'h30, 8'h77, 1);
    runSamples(0, 28, 0, "R5 saturate high");
    chk("R5 positive clamp", got[27], 8'hFF);
    loadPacket(8'h50, 8'h88, 1);
    runSamples(0, 28, 0, "R5 flat negative");
    loadPacket(8'h30, 8'h88, 1);
    runSamples(0, 28, 0, "R5 saturate low");
    chk("R5 negative clamp", got[27], 8'h00);

    // R8 empty at header
    doReq(v, lat, pops);
    chk("R8 empty header value", v, 8'h80);
    chk("R8 empty header pops", pops, 0);
    chk("R8 empty header latency", lat, 1);
    loadPacket(8'h12, 8'h33, 0);
    runSamples(0, 28, 0, "R8 after empty header");

    // R8 empty at first data byte
    pkt[0] = 8'h21;
    push(pkt[0]);
    doReq(v, lat, pops);
    chk("R8 empty data value", v, 8'h80);
    chk("R8 empty data pops", pops, 1);
    chk("R8 empty data latency", lat, 2);
    for (int k = 1; k < 15; k++) begin
      pkt[k] = (k * 29 + 7) & 255;
      push(pkt[k]);
    end
    runSamples(0, 28, 1, "R8 header retained");

    // R11 clear mid-packet
    loadPacket(8'h12, 8'h44, 0);
    runSamples(0, 5, 0, "R11 before clear");
    @(negedge clk);
    fifoClear = 1'b1;
    @(negedge clk);
    fifoClear = 1'b0;
    loadPacket(8'h21, 8'h66, 0);
    runSamples(0, 28, 0, "R11 after clear");

    chk("R9 no pop of empty FIFO", popEmptyErr, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired got %0d expected %0d", WATCHDOG, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule